// File: doc/BRIEF.md
# Block Floating Point Normalizer

This block takes frames of signed fixed-point complex samples on a framed stream. Each frame has a start marker on its first beat and an end marker on its last beat. While a frame arrives, the block stores every sample and keeps track of how far the largest real or imaginary part could be shifted left without overflow. Once the frame has closed, it sends the frame back out. Every sample is shifted left by that one common amount, so all samples share a single exponent. One extra beat then carries the shared exponent. A frame of N samples therefore leaves as N + 1 beats.

The exponent is a signed two's-complement number. It is zero or negative and equals minus the applied left shift, so the true value of each sample is its mantissa times two to the exponent. The shift is set by the largest sample, so small samples in a frame that also holds a large one keep few significant bits. This loss of precision is accepted. Input is refused while a frame is being sent out, and the output side may stall any beat by holding its ready input low.

Top module: `blkfp_normalizer`

## Requirements
- R1: After reset, in_ready is high and out_valid is low.
- R2: No output beat is presented (out_valid low) while a frame is still being received; output begins in the cycle after the frame's closing beat is accepted.
- R3: The exponent beat carries out_exp = -H as an EW-bit two's-complement value. H is the smallest, over all real and imaginary parts of the frame, of the number of leading bits that repeat the sign bit (a value's own sign bit not counted).
- R4: Each data beat carries out_re and out_im equal to the stored sample's real and imaginary parts, each shifted left by the same H bits.
- R5: A frame of L samples leaves as L data beats in arrival order, followed by one exponent beat. out_sop is high on the first data beat only. out_expslot and out_eop are high on the exponent beat only, and out_re and out_im are zero on that beat.
- R6: A frame whose samples are all zero gives exponent 0 and zero mantissas.
- R7: in_ready is low whenever out_valid is high. A beat presented with out_ready low is held unchanged until out_ready is high.
- R8: While no frame is open, input beats without in_sop are dropped and have no effect on later frames.
- R9: A frame closes on the beat with in_eop, or on its N-th sample if in_eop never comes.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept an input beat |
| in_sop | input | 1 | First sample of a frame |
| in_eop | input | 1 | Last sample of a frame |
| in_re | input | DW | Real part, signed |
| in_im | input | DW | Imaginary part, signed |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sop | output | 1 | First data beat of a frame |
| out_eop | output | 1 | Last beat of a frame (exponent beat) |
| out_expslot | output | 1 | Current beat carries the exponent |
| out_re | output | DW | Real mantissa |
| out_im | output | DW | Imaginary mantissa |
| out_exp | output | EW | Shared exponent, signed, valid on the exponent beat |

## Verification
Errors in the headroom tracker or the all-zero flag show up on the exponent beat. They appear as a wrong out_exp and, on the data beats of the same frame, as mantissas shifted by the wrong amount. Both become visible within N + 1 accepted beats of the frame's close. A corrupted write or read pointer shows up as a sample out of order, or as a marker on the wrong beat, in the first frame it affects. A stall bug shows up as a beat whose content changes while out_ready is low. Beats that should have been dropped but were stored would change the exponent of the next frame.

// File: rtl/blkfp_pkg.sv
// Shared types of the block floating point normalizer.
package blkfp_pkg;
    // Frame handling phase of the top-level sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_t;
endpackage

// File: rtl/blkfp_signrun.sv
// Counts the leading bits of a signed value that repeat its sign bit,
// excluding the sign bit itself: the left shift the value can take
// without overflow. Purely combinational. Assumes DW >= 2.
module blkfp_signrun #(
    parameter int DW = 16,
    parameter int CW = $clog2(DW)
) (
    input  logic [DW-1:0] value,
    output logic [CW-1:0] spare
);
    logic run;

    // Walk down from below the sign bit while bits copy the sign.
    always_comb begin
        spare = '0;
        run   = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (value[i] == value[DW-1])) begin
                spare = CW'(spare + 1'b1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/blkfp_track.sv
// Keeps the running minimum headroom and an any-nonzero flag over the
// accepted samples of one frame. A 'clear' beat restarts both.
// Assumes outputs are only consumed after the frame's last beat.
module blkfp_track #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          clear,
    input  logic [CW-1:0] hr_a,
    input  logic [CW-1:0] hr_b,
    input  logic          nz_in,
    output logic [CW-1:0] hr_min,
    output logic          any_nz
);
    logic [CW-1:0] beat_min;

    // Smaller headroom of the two parts of the current beat.
    always_comb begin
        beat_min = (hr_a < hr_b) ? hr_a : hr_b;
    end

    // Fold the current beat into the frame statistics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_min <= '0;
            any_nz <= 1'b0;
        end else if (take) begin
            if (clear) begin
                hr_min <= beat_min;
                any_nz <= nz_in;
            end else begin
                hr_min <= (beat_min < hr_min) ? beat_min : hr_min;
                any_nz <= any_nz | nz_in;
            end
        end
    end
endmodule

// File: rtl/blkfp_framebuf.sv
// Simple dual-port frame store: synchronous write, asynchronous read,
// real and imaginary halves side by side. No reset on the contents.
module blkfp_framebuf #(
    parameter int DW = 16,
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wre,
    input  logic [DW-1:0] wim,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rre,
    output logic [DW-1:0] rim
);
    logic [DW-1:0] mem_re [N];
    logic [DW-1:0] mem_im [N];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_re[waddr] <= wre;
            mem_im[waddr] <= wim;
        end
    end

    // Read port.
    always_comb begin
        rre = mem_re[raddr];
        rim = mem_im[raddr];
    end
endmodule

// File: rtl/blkfp_normalizer.sv
// Block floating point normalizer. Buffers one frame of complex
// samples, finds the smallest headroom over all parts, then re-emits
// each sample shifted left by it, followed by one exponent beat.
// Assumes N >= 2 and DW - 1 <= 2**(EW-1) so the exponent fits.
module blkfp_normalizer
    import blkfp_pkg::*;
#(
    parameter int DW = 16,
    parameter int EW = 6,
    parameter int N  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sop,
    output logic          out_eop,
    output logic          out_expslot,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic [EW-1:0] out_exp
);
    localparam int CW = $clog2(DW);
    localparam int IW = $clog2(N);
    localparam int AW = $clog2(N + 1);

    phase_t        phase;
    logic [AW-1:0] wcnt, rcnt, flen, cnt_now;
    logic          accept, start, take, last, data_beat;
    logic [CW-1:0] hr_re, hr_im, hr_min, eff_shift;
    logic          any_nz;
    logic [DW-1:0] rd_re, rd_im;

    // Input side handshake and frame boundary decode.
    always_comb begin
        in_ready = (phase != PH_DRAIN);
        accept   = in_valid && in_ready;
        start    = accept && in_sop;
        take     = accept && (in_sop || (phase == PH_FILL));
        cnt_now  = start ? '0 : wcnt;
        last     = take && (in_eop || (cnt_now == AW'(N - 1)));
    end

    blkfp_signrun #(.DW(DW), .CW(CW)) u_run_re (.value(in_re), .spare(hr_re));
    blkfp_signrun #(.DW(DW), .CW(CW)) u_run_im (.value(in_im), .spare(hr_im));

    blkfp_track #(.CW(CW)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .clear  (start),
        .hr_a   (hr_re),
        .hr_b   (hr_im),
        .nz_in  ((|in_re) || (|in_im)),
        .hr_min (hr_min),
        .any_nz (any_nz)
    );

    blkfp_framebuf #(.DW(DW), .N(N), .IW(IW)) u_buf (
        .clk   (clk),
        .we    (take),
        .waddr (cnt_now[IW-1:0]),
        .wre   (in_re),
        .wim   (in_im),
        .raddr (rcnt[IW-1:0]),
        .rre   (rd_re),
        .rim   (rd_im)
    );

    // Phase, write count, frame length and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            wcnt  <= '0;
            rcnt  <= '0;
            flen  <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_FILL: begin
                    if (take) begin
                        wcnt <= AW'(cnt_now + 1'b1);
                        if (last) begin
                            phase <= PH_DRAIN;
                            flen  <= AW'(cnt_now + 1'b1);
                            rcnt  <= '0;
                        end else begin
                            phase <= PH_FILL;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (out_ready) begin
                        if (rcnt == flen) begin
                            phase <= PH_IDLE;
                            wcnt  <= '0;
                        end else begin
                            rcnt <= AW'(rcnt + 1'b1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output beat formation: shifted mantissas, then the exponent slot.
    always_comb begin
        eff_shift   = any_nz ? hr_min : '0;
        out_valid   = (phase == PH_DRAIN);
        data_beat   = out_valid && (rcnt < flen);
        out_sop     = data_beat && (rcnt == '0);
        out_expslot = out_valid && !data_beat;
        out_eop     = out_expslot;
        out_re      = data_beat ? DW'(rd_re << eff_shift) : '0;
        out_im      = data_beat ? DW'(rd_im << eff_shift) : '0;
        out_exp     = out_expslot ? EW'(-EW'(eff_shift)) : '0;
    end
endmodule

// File: rtl/blkfp_checker.sv
// Port-level properties of the normalizer, bound to every instance.
module blkfp_checker #(
    parameter int DW = 16,
    parameter int EW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_sop,
    input logic          out_eop,
    input logic          out_expslot,
    input logic [DW-1:0] out_re,
    input logic [DW-1:0] out_im,
    input logic [EW-1:0] out_exp
);
    // R7: no input acceptance while a frame is being sent.
    assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7: a stalled beat is held unchanged.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                       && $stable(out_exp) && $stable(out_expslot)
                                       && $stable(out_sop)));

    // R5: end marker only on the exponent slot, start marker never there.
    assert_eop_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_eop || out_sop)) |-> (out_eop == out_expslot) && !(out_sop && out_expslot));

    // R5: exponent slot carries zero data.
    assert_slot_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_expslot) |-> (out_re == '0) && (out_im == '0));

    // R3: exponent is never positive.
    assert_exp_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_expslot) |-> ($signed(out_exp) <= 0));

    // R5: after the exponent slot is taken, the frame output ends.
    assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_expslot && out_ready) |=> !out_valid);
endmodule

bind blkfp_normalizer blkfp_checker #(.DW(DW), .EW(EW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_expslot (out_expslot),
    .out_re      (out_re),
    .out_im      (out_im),
    .out_exp     (out_exp)
);

// File: tb/sim_blkfp_normalizer.sv
`timescale 1ns/1ps
module sim_blkfp_normalizer;
    localparam int DW = 16;
    localparam int EW = 6;
    localparam int N  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_re = '0, in_im = '0;
    logic          out_ready = 1'b0;
    logic          in_ready, out_valid, out_sop, out_eop, out_expslot;
    logic [DW-1:0] out_re, out_im;
    logic [EW-1:0] out_exp;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] fr_re [N];
    logic [DW-1:0] fr_im [N];

    always #4 clk = ~clk;

    blkfp_normalizer #(.DW(DW), .EW(EW), .N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_expslot(out_expslot), .out_re(out_re),
        .out_im(out_im), .out_exp(out_exp)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Left shift a value survives intact, found by trial shifting.
    function automatic int ref_room(input logic [DW-1:0] x);
        int h = 0;
        for (int k = 1; k < DW; k++) begin
            logic signed [DW-1:0] t;
            t = $signed(x) <<< k;
            if ((t >>> k) == $signed(x)) h = k;
        end
        return h;
    endfunction

    function automatic int ref_shift(input int len);
        int h = DW - 1;
        bit nz = 0;
        for (int i = 0; i < len; i++) begin
            if (ref_room(fr_re[i]) < h) h = ref_room(fr_re[i]);
            if (ref_room(fr_im[i]) < h) h = ref_room(fr_im[i]);
            if (fr_re[i] != 0 || fr_im[i] != 0) nz = 1;
        end
        return nz ? h : 0;
    endfunction

    task automatic send_frame(input int len, input bit with_eop);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R2 no output while filling", out_valid, 0);
            chk(in_ready == 1'b1, "R7 ready during fill", in_ready, 1);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == len - 1);
            in_re    = fr_re[i];
            in_im    = fr_im[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic recv_frame(input int len, input string tag);
        int sh = ref_shift(len);
        int idx = 0;
        int guard = 0;
        logic [DW-1:0] er, ei;
        logic [EW-1:0] ee;
        bit held = 0;
        logic [DW-1:0] hr, hi;
        chk(out_valid == 1'b1, "R2 output starts after close", out_valid, 1);
        while (idx <= len && guard < 200) begin
            guard++;
            out_ready = ($urandom % 4) != 0;
            #1;
            chk(out_valid == 1'b1 && in_ready == 1'b0, "R7 valid with ready low",
                {out_valid, in_ready}, 2'b10);
            if (held) chk(out_re == hr && out_im == hi, "R7 stalled beat held", out_re, hr);
            if (idx < len) begin
                er = DW'(fr_re[idx] << sh);
                ei = DW'(fr_im[idx] << sh);
                chk(out_re == er, {tag, " R4 real mantissa"}, out_re, er);
                chk(out_im == ei, {tag, " R4 imag mantissa"}, out_im, ei);
                chk(out_sop == (idx == 0) && !out_expslot && !out_eop, {tag, " R5 data markers"},
                    {out_sop, out_eop, out_expslot}, {(idx == 0), 2'b00});
            end else begin
                ee = EW'(-sh);
                chk(out_exp == ee, {tag, " R3 exponent"}, out_exp, ee);
                chk(out_expslot && out_eop && !out_sop && out_re == 0 && out_im == 0,
                    {tag, " R5 exponent slot"}, {out_sop, out_eop, out_expslot}, 3'b011);
            end
            held = !out_ready;
            hr = out_re; hi = out_im;
            if (out_ready) idx++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R5 frame output ended", {out_valid, in_ready}, 2'b01);
    endtask

    task automatic fill_random();
        int s = $urandom % DW;
        for (int i = 0; i < N; i++) begin
            fr_re[i] = DW'($signed(DW'($urandom)) >>> s);
            fr_im[i] = DW'($signed(DW'($urandom)) >>> s);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", {in_ready, out_valid}, 2'b10);

        // R6: all-zero frame.
        for (int i = 0; i < N; i++) begin fr_re[i] = '0; fr_im[i] = '0; end
        send_frame(N, 1); recv_frame(N, "R6 zero frame");

        // R3: most negative value leaves no headroom.
        for (int i = 0; i < N; i++) begin fr_re[i] = 16'h0003; fr_im[i] = 16'hfffe; end
        fr_re[5] = 16'h8000;
        send_frame(N, 1); recv_frame(N, "R3 full scale");

        // R3: all minus one gives the deepest shift.
        for (int i = 0; i < N; i++) begin fr_re[i] = 16'hffff; fr_im[i] = 16'hffff; end
        send_frame(N, 1); recv_frame(N, "R3 minus one");

        // R4: large imaginary part limits both parts.
        for (int i = 0; i < N; i++) begin fr_re[i] = 16'h0001; fr_im[i] = 16'h0002; end
        fr_im[7] = 16'h0400;
        send_frame(N, 1); recv_frame(N, "R4 shared shift");

        // R8: stray beats before the start marker are dropped.
        @(negedge clk);
        in_valid = 1'b1; in_re = 16'h4000; in_im = 16'hc000;
        @(negedge clk);
        in_re = 16'h7000;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < N; i++) begin fr_re[i] = DW'(i); fr_im[i] = DW'(-i); end
        send_frame(N, 1); recv_frame(N, "R8 stray dropped");

        // R9: frame closes on the N-th sample without an end marker.
        fill_random();
        send_frame(N, 0); recv_frame(N, "R9 no eop");

        // R9: short frame closed by the end marker.
        fill_random();
        send_frame(3, 1); recv_frame(3, "R9 short frame");

        // Random frames.
        for (int f = 0; f < 40; f++) begin
            fill_random();
            send_frame(N, 1); recv_frame(N, "random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule